// File: doc/BRIEF.md
# Converter Start-Up and Shutdown Sequencer

This block decides when a multiphase converter may switch and which voltage it should ramp toward during power-up. It watches three already-synchronized qualification flags (bias supply healthy, power-rail enable, termination-rail enable). Only when all three are true together does it leave shutdown. After a fixed wait it asks a downstream slew controller to ramp to a boot voltage. That voltage is a hard-wired code, or the first received voltage command when the hard-wired code is zero.

Once the output sits in its regulation window, the sequencer dwells for a fixed time and then raises a request for the operating voltage code. A nonzero answer starts a second ramp to that code. The ready flag rises when the output is back in its window. An answer of zero keeps the converter switched off. Dropping any qualification flag turns switching and ready off in the same cycle, and the sequence then starts again from the beginning.

Top module: `pwr_seq`

## Requirements
- R1: While reset is asserted, `pwm_en`, `ready`, `vid_req` and `ramp_start` are 0 and `ramp_target` is 0.
- R2: The sequencer leaves shutdown only when `bias_ok`, `pwr_en` and `term_en` are all 1 at the same clock edge. With any one of them at 0, every output stays 0.
- R3: While in shutdown, or while any of the three flags is 0, `pwm_en` is 0, which holds the phase drivers off.
- R4: The sequencer counts edges starting with the first edge at which all three flags are 1. At the DELAY_CYC-th edge after that one, `ramp_start` pulses and `pwm_en` rises together with it. At the same edge `ramp_target` takes `boot_code`, provided `boot_code` is nonzero.
- R5: When `boot_code` is 0, the sequencer waits after the delay with `pwm_en` at 0. A later `cmd_valid` carrying a nonzero `cmd_vid` loads that value into `ramp_target`, pulses `ramp_start` and raises `pwm_en` at the next edge.
- R6: After the boot ramp, the sequencer waits for `out_in_win`. It then dwells DWELL_CYC edges and raises `vid_req`. `vid_req` stays 1 until a `cmd_valid` arrives.
- R7: A `cmd_valid` with nonzero `cmd_vid` while `vid_req` is 1 clears `vid_req`, loads `ramp_target` with `cmd_vid` and pulses `ramp_start` at the next edge.
- R8: A `cmd_valid` with `cmd_vid` equal to 8'h00 (the off code) while `vid_req` is 1 turns `pwm_en` off. Switching stays off, and later commands and window changes have no effect, until a flag drops.
- R9: `ready` rises at the edge that first sees `out_in_win` at 1 after the final ramp was started. It then stays 1, regardless of `out_in_win`, while all three flags remain 1.
- R10: Losing any of the three flags forces `pwm_en`, `ready` and `vid_req` to 0 within the same cycle. It also clears `ramp_target` to 0 at the next edge, and start-up then begins again from the delay.
- R11: `ramp_start` is never 1 for two consecutive cycles.
- R12: `cmd_valid` has no effect outside the boot-command wait and the VID request. This covers the start-up delay and the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on threshold (synchronized) |
| pwr_en | input | 1 | Power-rail enable (synchronized) |
| term_en | input | 1 | Termination-rail enable (synchronized) |
| boot_code | input | VID_W | Hard-wired boot voltage code; 0 selects first-command boot |
| cmd_valid | input | 1 | One-cycle strobe of a received voltage command |
| cmd_vid | input | VID_W | Voltage code carried by the command; 0 is the off code |
| out_in_win | input | 1 | Output voltage is inside its regulation window |
| pwm_en | output | 1 | Phase drivers may switch; 0 holds them in the off (high-impedance) state |
| ramp_target | output | VID_W | Target code for the slew controller |
| ramp_start | output | 1 | One-cycle request to begin a ramp toward `ramp_target` |
| vid_req | output | 1 | Request to read the operating voltage code |
| ready | output | 1 | Output regulated after soft-start |

## Verification
The properties assume the three qualification flags are already synchronized to `clk` and clean. They also assume `cmd_valid` is a single-cycle strobe, and that `out_in_win` only means something after a ramp has been launched. The bench changes every input on the falling edge and holds it for whole cycles, so no flag glitches within a cycle. Commands are issued only as isolated pulses or short runs whose effect is stated in a requirement. The window flag is raised only where the expected state is known, so each ramp and dwell boundary lands on a predictable edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_SHUT,
    ST_DELAY,
    ST_WAIT_CMD,
    ST_BOOT_RAMP,
    ST_DWELL,
    ST_READ_VID,
    ST_FINAL_RAMP,
    ST_RUN,
    ST_OFF_HOLD
  } seq_state_e;

  // all three qualification flags at once
  function automatic logic enables_met(input logic bias, input logic pwr, input logic term);
    return bias & pwr & term;
  endfunction

  // states in which the phases are allowed to switch
  function automatic logic drives_pwm(input seq_state_e s);
    return (s == ST_BOOT_RAMP) || (s == ST_DWELL) || (s == ST_READ_VID) ||
           (s == ST_FINAL_RAMP) || (s == ST_RUN);
  endfunction

  // states that use the shared cycle timer
  function automatic logic timed_state(input seq_state_e s);
    return (s == ST_DELAY) || (s == ST_DWELL);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = run && (cnt == (limit - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (run && !done) cnt <= cnt + CNT_W'(1);
    else                  cnt <= '0;
  end

endmodule

// File: rtl/pwr_seq_target.sv
module pwr_seq_target #(
  parameter int unsigned VID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [VID_W-1:0] value,
  output logic [VID_W-1:0] target,
  output logic             start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target <= '0;
      start  <= 1'b0;
    end else begin
      start <= load & ~clr;
      if (clr)       target <= '0;
      else if (load) target <= value;
    end
  end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned VID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_ok,
  input  logic [VID_W-1:0] boot_code,
  input  logic             cmd_valid,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             in_win,
  input  logic             tmr_done,
  output seq_state_e       st,
  output logic             load,
  output logic [VID_W-1:0] load_val
);

  seq_state_e nxt;
  logic       cmd_off;

  assign cmd_off = (cmd_vid == '0);

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    load_val = boot_code;
    if (!en_ok) begin
      nxt = ST_SHUT;
    end else begin
      case (st)
        ST_SHUT:  nxt = ST_DELAY;
        ST_DELAY: begin
          if (tmr_done) begin
            if (boot_code != '0) begin
              nxt  = ST_BOOT_RAMP;
              load = 1'b1;
            end else begin
              nxt = ST_WAIT_CMD;
            end
          end
        end
        ST_WAIT_CMD: begin
          if (cmd_valid) begin
            if (cmd_off) begin
              nxt = ST_OFF_HOLD;
            end else begin
              nxt      = ST_BOOT_RAMP;
              load     = 1'b1;
              load_val = cmd_vid;
            end
          end
        end
        ST_BOOT_RAMP: if (in_win) nxt = ST_DWELL;
        ST_DWELL:     if (tmr_done) nxt = ST_READ_VID;
        ST_READ_VID: begin
          if (cmd_valid) begin
            if (cmd_off) begin
              nxt = ST_OFF_HOLD;
            end else begin
              nxt      = ST_FINAL_RAMP;
              load     = 1'b1;
              load_val = cmd_vid;
            end
          end
        end
        ST_FINAL_RAMP: if (in_win) nxt = ST_RUN;
        ST_RUN:        nxt = ST_RUN;
        ST_OFF_HOLD:   nxt = ST_OFF_HOLD;
        default:       nxt = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_SHUT;
    else        st <= nxt;
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned VID_W     = 8,
  parameter int unsigned DELAY_CYC = 16,
  parameter int unsigned DWELL_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bias_ok,
  input  logic             pwr_en,
  input  logic             term_en,
  input  logic [VID_W-1:0] boot_code,
  input  logic             cmd_valid,
  input  logic [VID_W-1:0] cmd_vid,
  input  logic             out_in_win,
  output logic             pwm_en,
  output logic [VID_W-1:0] ramp_target,
  output logic             ramp_start,
  output logic             vid_req,
  output logic             ready
);

  localparam int unsigned CNT_MAX = max_of(DELAY_CYC, DWELL_CYC);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  // named internal events
  seq_state_e       evt_state;
  logic             evt_en_ok;
  logic             evt_tmr_run;
  logic             evt_tmr_done;
  logic             evt_load;
  logic [VID_W-1:0] evt_load_val;
  logic             evt_start;
  logic [CNT_W-1:0] tmr_limit;

  assign evt_en_ok   = enables_met(bias_ok, pwr_en, term_en);
  assign evt_tmr_run = timed_state(evt_state);
  assign tmr_limit   = (evt_state == ST_DELAY) ? CNT_W'(DELAY_CYC) : CNT_W'(DWELL_CYC);

  pwr_seq_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (evt_tmr_run),
    .limit (tmr_limit),
    .done  (evt_tmr_done)
  );

  pwr_seq_fsm #(.VID_W(VID_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_ok     (evt_en_ok),
    .boot_code (boot_code),
    .cmd_valid (cmd_valid),
    .cmd_vid   (cmd_vid),
    .in_win    (out_in_win),
    .tmr_done  (evt_tmr_done),
    .st        (evt_state),
    .load      (evt_load),
    .load_val  (evt_load_val)
  );

  pwr_seq_target #(.VID_W(VID_W)) i_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (~evt_en_ok),
    .load   (evt_load),
    .value  (evt_load_val),
    .target (ramp_target),
    .start  (evt_start)
  );

  assign pwm_en     = evt_en_ok & drives_pwm(evt_state);
  assign ready      = evt_en_ok & (evt_state == ST_RUN);
  assign vid_req    = evt_en_ok & (evt_state == ST_READ_VID);
  assign ramp_start = evt_en_ok & evt_start;

endmodule

// File: rtl/pwr_seq_sva.sv
module pwr_seq_sva #(
  parameter int unsigned VID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bias_ok,
  input logic             pwr_en,
  input logic             term_en,
  input logic             cmd_valid,
  input logic [VID_W-1:0] cmd_vid,
  input logic             out_in_win,
  input logic             pwm_en,
  input logic [VID_W-1:0] ramp_target,
  input logic             ramp_start,
  input logic             vid_req,
  input logic             ready
);

  logic en_all;
  assign en_all = bias_ok & pwr_en & term_en;

  // R10
  lost_enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_all |-> (!pwm_en && !ready && !vid_req));

  // R9
  ready_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(out_in_win));

  // R11
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start |=> !ramp_start);

  // R4
  pwm_on_with_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> ramp_start);

  // R7
  vid_loads_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all && vid_req && cmd_valid && cmd_vid != '0) |=>
      (ramp_start && !vid_req && ramp_target == $past(cmd_vid)));

  // R8
  off_code_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all && vid_req && cmd_valid && cmd_vid == '0) |=> (!pwm_en && !ramp_start));

  // R6
  req_only_switching_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_req |-> (pwm_en && !ready));

endmodule

bind pwr_seq pwr_seq_sva #(.VID_W(VID_W)) i_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .bias_ok     (bias_ok),
  .pwr_en      (pwr_en),
  .term_en     (term_en),
  .cmd_valid   (cmd_valid),
  .cmd_vid     (cmd_vid),
  .out_in_win  (out_in_win),
  .pwm_en      (pwm_en),
  .ramp_target (ramp_target),
  .ramp_start  (ramp_start),
  .vid_req     (vid_req),
  .ready       (ready)
);

// File: tb/test_pwr_seq.sv
module test_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int VW         = 8;
  localparam int D_CYC      = 3;
  localparam int W_CYC      = 2;
  localparam int NVEC       = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bias_ok = 1'b0, pwr_en = 1'b0, term_en = 1'b0;
  logic [VW-1:0] boot_code = 8'h40;
  logic          cmd_valid = 1'b0;
  logic [VW-1:0] cmd_vid = '0;
  logic          out_in_win = 1'b0;
  logic          pwm_en, ramp_start, vid_req, ready;
  logic [VW-1:0] ramp_target;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq #(.VID_W(VW), .DELAY_CYC(D_CYC), .DWELL_CYC(W_CYC)) i_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .pwr_en(pwr_en), .term_en(term_en),
    .boot_code(boot_code), .cmd_valid(cmd_valid), .cmd_vid(cmd_vid), .out_in_win(out_in_win),
    .pwm_en(pwm_en), .ramp_target(ramp_target), .ramp_start(ramp_start),
    .vid_req(vid_req), .ready(ready)
  );

  // vector: en[24:22] {bias,pwr,term}, cv[21], vid[20:13], win[12],
  //         exp {pwm,rdy,req,start}[11:8], exp target[7:0]; boot_code = 8'h40
  localparam logic [24:0] TBL [NVEC] = '{
    {3'b000, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  0 R3
    {3'b110, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  1 R2
    {3'b101, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  2 R2
    {3'b011, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  3 R2
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  4 R4 delay starts
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, //  5 R4
    {3'b111, 1'b1, 8'h77, 1'b0, 4'b0000, 8'h00}, //  6 R12 command in delay
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1001, 8'h40}, //  7 R4 boot ramp
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1000, 8'h40}, //  8 R11
    {3'b111, 1'b0, 8'h00, 1'b1, 4'b1000, 8'h40}, //  9 R6 dwell
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1000, 8'h40}, // 10 R6
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1010, 8'h40}, // 11 R6 request
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1010, 8'h40}, // 12 R6 held
    {3'b111, 1'b1, 8'h55, 1'b0, 4'b1001, 8'h55}, // 13 R7
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1000, 8'h55}, // 14 R9 not yet
    {3'b111, 1'b0, 8'h00, 1'b1, 4'b1100, 8'h55}, // 15 R9
    {3'b111, 1'b1, 8'h22, 1'b1, 4'b1100, 8'h55}, // 16 R12 command in run
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1100, 8'h55}, // 17 R9 stays
    {3'b011, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, // 18 R10
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, // 19 R10 restart
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, // 20
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}, // 21
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1001, 8'h40}, // 22 R4
    {3'b111, 1'b0, 8'h00, 1'b1, 4'b1000, 8'h40}, // 23
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1000, 8'h40}, // 24
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b1010, 8'h40}, // 25 R6
    {3'b111, 1'b1, 8'h00, 1'b0, 4'b0000, 8'h40}, // 26 R8 off code
    {3'b111, 1'b1, 8'h33, 1'b1, 4'b0000, 8'h40}, // 27 R8 stays off
    {3'b111, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h40}, // 28 R8
    {3'b110, 1'b0, 8'h00, 1'b0, 4'b0000, 8'h00}  // 29 R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic outs(input string req, input logic [3:0] fl, input logic [7:0] tg);
    chk(req, {28'd0, pwm_en, ready, vid_req, ramp_start}, {28'd0, fl});
    chk(req, {24'd0, ramp_target}, {24'd0, tg});
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [24:0] v;
    // R1 reset state
    repeat (3) @(negedge clk);
    outs("R1", 4'b0000, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      v = TBL[i];
      @(negedge clk);
      {bias_ok, pwr_en, term_en} = v[24:22];
      cmd_valid  = v[21];
      cmd_vid    = v[20:13];
      out_in_win = v[12];
      @(posedge clk);
      #1;
      outs($sformatf("R-vector %0d", i), v[11:8], v[7:0]);
    end

    // R10: same-cycle shutdown from running state
    @(negedge clk);
    cmd_valid = 1'b0; out_in_win = 1'b1; term_en = 1'b1;
    edges(D_CYC + 1 + W_CYC + 1);
    chk("R6 request", {31'd0, vid_req}, 32'd1);
    @(negedge clk); cmd_valid = 1'b1; cmd_vid = 8'h60;
    edges(1);
    @(negedge clk); cmd_valid = 1'b0;
    edges(1);
    chk("R9 ready", {31'd0, ready}, 32'd1);
    @(negedge clk); term_en = 1'b0;
    #1;
    chk("R10 pwm same cycle", {31'd0, pwm_en}, 32'd0);
    chk("R10 ready same cycle", {31'd0, ready}, 32'd0);
    edges(1);
    chk("R10 target cleared", {24'd0, ramp_target}, 32'h0);

    // R5 boot from first command, with commands in delay ignored (R12)
    @(negedge clk);
    boot_code = 8'h00; out_in_win = 1'b0; term_en = 1'b1;
    cmd_valid = 1'b1; cmd_vid = 8'h44;
    edges(D_CYC);
    @(negedge clk); cmd_valid = 1'b0;
    edges(1);
    outs("R12 delay ignores command", 4'b0000, 8'h00);
    edges(2);
    outs("R5 waits for command", 4'b0000, 8'h00);
    @(negedge clk); cmd_valid = 1'b1; cmd_vid = 8'h2A;
    edges(1);
    outs("R5 first command boot", 4'b1001, 8'h2A);
    @(negedge clk); cmd_valid = 1'b0;
    edges(1);
    outs("R11 pulse ends", 4'b1000, 8'h2A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule